// File: doc/BRIEF.md
# Transaction Nesting and Abort Controller

This block keeps the hardware transaction state of one processor core. The decode stage hands it one operation per cycle: begin, constrained begin, end or explicit abort. The memory system raises a conflict line when another agent touches the transaction's footprint. The block tracks the nesting level and reports it on a query output. It grants or refuses each begin through a condition code and issues a commit strobe when the outermost level ends. Speculative state is kept elsewhere, and this block only emits the commit and discard strobes that control it.

Nesting is flat. Inner begins only count levels, so every abort unwinds to the outermost begin and clears the level to zero. At the outermost begin the block captures a register-restore mask, the resume address and the register values that the mask selects. On any abort it presents these so the core can restore the selected registers and branch back with a nonzero condition code. It also writes a 256-byte diagnostic record, one 64-bit word per cycle, holding the abort reason, the level and the register file as it stood when the abort was taken.

Top module: `tx_nest_ctrl`

## Requirements
- R1: After reset, and whenever no transaction is open, `depth_o` is 0 and `in_tx_o` is low. No strobe (`cc_valid_o`, `commit_o`, `discard_o`, `seq_exc_o`, `resume_valid_o`, `diag_we_o`) is raised without a triggering operation.
- R2: A begin (`op_kind_i` = 1) below the depth limit raises the depth by one. One cycle later it returns `cc_valid_o` with `cc_o` = 0.
- R3: A begin at depth `MAX_DEPTH` aborts the transaction with abort code 0x03 and condition code 3.
- R4: Every abort sets the depth to 0 and pulses `discard_o` and `resume_valid_o` together with `cc_valid_o`, using a nonzero `cc_o`. `resume_pc_o` carries the address given with the outermost begin, and addresses given with inner begins are ignored.
- R5: A conflict while the depth is nonzero aborts with code 0x02 and condition code 2. It wins over any operation in the same cycle. A conflict at depth 0 has no effect.
- R6: An explicit abort (`op_kind_i` = 4) at nonzero depth behaves like a conflict abort, with condition code 2, but records the code given on `op_code_i`.
- R7: An end (`op_kind_i` = 3) at depth 1 pulses `commit_o` for one cycle and returns the depth to 0. At a greater depth it only lowers the depth by one. At depth 0 it pulses `seq_exc_o` and changes nothing else.
- R8: An explicit abort at depth 0 pulses `seq_exc_o` and causes no abort.
- R9: Mask bit k selects general registers 2k and 2k+1. On abort, `restore_mask_o` holds the expanded 16-bit mask of the outermost begin. `restore_data_o` holds, for each selected register, its value at that begin, and zero for the other registers.
- R10: A constrained begin (`op_kind_i` = 2) at depth 0 enters depth 1 with condition code 0. A constrained begin at nonzero depth, or any begin inside a constrained transaction, aborts with code 0x04 and condition code 3.
- R11: Starting in the cycle `resume_valid_o` is high, the block writes 32 words at addresses 0 to 31, one per cycle. The words are: word 0 the abort code, word 1 the depth when the abort was taken, word 2 the resume address, words 3 to 15 zero, and words 16 to 31 registers 0 to 15 as they were on `gpr_i` in the abort cycle. A new abort restarts the record at address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid_i | input | 1 | An operation is presented this cycle |
| op_kind_i | input | 3 | 1 begin, 2 constrained begin, 3 end, 4 explicit abort |
| op_mask_i | input | 8 | Register-pair restore mask carried by a begin |
| op_code_i | input | 8 | Abort code carried by an explicit abort |
| op_pc_i | input | PC_W | Address of the instruction after the begin |
| conflict_i | input | 1 | Memory conflict detected |
| gpr_i | input | 16*XLEN | Current general register file, register n at bits n*XLEN |
| depth_o | output | DEPTH_W | Current nesting depth |
| in_tx_o | output | 1 | Depth is nonzero |
| cc_valid_o | output | 1 | Condition code for a begin or abort is valid |
| cc_o | output | 2 | Condition code |
| commit_o | output | 1 | Outermost end, commit speculative state |
| discard_o | output | 1 | Abort, drop speculative state |
| seq_exc_o | output | 1 | End or explicit abort outside a transaction |
| resume_valid_o | output | 1 | Redirect fetch to the resume address |
| resume_pc_o | output | PC_W | Resume address from the outermost begin |
| restore_valid_o | output | 1 | Restore selected registers |
| restore_mask_o | output | 16 | Registers to restore |
| restore_data_o | output | 16*XLEN | Begin-time values of the selected registers |
| diag_we_o | output | 1 | Diagnostic record word write |
| diag_addr_o | output | DIAG_AW | Word index in the record |
| diag_data_o | output | DIAG_W | Word written |

## Verification
Every decision the block makes is registered once. Depth, condition code, commit, discard, exception, resume and restore results are all visible in the cycle after the edge that samples the operation. The bench drives each operation on a falling edge and samples shortly after the next rising edge. Diagnostic word k lands k cycles after the first one, which appears together with the resume strobe. After an abort, the bench therefore steps one rising edge per word and compares address and data there. Expected values come from a bench-side model of depth, constrained flag, outermost mask, address and captured registers, which is updated only after each comparison.

// File: rtl/tx_nest_pkg.sv
`timescale 1ns/1ps
// Shared encodings for the transaction nesting controller.
// Assumes a 16-entry general register file and 8-bit abort codes.
package tx_nest_pkg;

    typedef enum logic [2:0] {
        TXOP_NONE   = 3'd0,
        TXOP_BEGIN  = 3'd1,
        TXOP_CBEGIN = 3'd2,
        TXOP_END    = 3'd3,
        TXOP_ABORT  = 3'd4
    } txop_e;

    localparam int NUM_GPR   = 16;
    localparam int PAIR_CNT  = NUM_GPR / 2;
    localparam int CODE_W    = 8;

    localparam logic [CODE_W-1:0] CODE_CONFLICT = 8'h02;
    localparam logic [CODE_W-1:0] CODE_OVERFLOW = 8'h03;
    localparam logic [CODE_W-1:0] CODE_CNEST    = 8'h04;

    localparam logic [1:0] CC_OK      = 2'd0;
    localparam logic [1:0] CC_RETRY   = 2'd2;
    localparam logic [1:0] CC_PERSIST = 2'd3;

    // Expand a per-pair mask into a per-register mask.
    function automatic logic [NUM_GPR-1:0] pair_expand(input logic [PAIR_CNT-1:0] m);
        logic [NUM_GPR-1:0] r;
        for (int i = 0; i < PAIR_CNT; i++) begin
            r[2*i]   = m[i];
            r[2*i+1] = m[i];
        end
        return r;
    endfunction

endpackage

// File: rtl/tx_depth_ctrl.sv
`timescale 1ns/1ps
// Nesting depth and abort decision.
// Decides per cycle whether the operation or conflict commits, nests,
// unwinds or aborts. Registered strobes appear one cycle after the
// sampling edge. Assumes at most one operation per cycle; a conflict
// at nonzero depth overrides the operation.
module tx_depth_ctrl
    import tx_nest_pkg::*;
#(
    parameter int MAX_DEPTH = 15,
    parameter int DEPTH_W   = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                op_valid_i,
    input  txop_e               op_kind_i,
    input  logic [CODE_W-1:0]   op_code_i,
    input  logic                conflict_i,
    output logic [DEPTH_W-1:0]  depth_o,
    output logic                constrained_o,
    output logic                cc_valid_o,
    output logic [1:0]          cc_o,
    output logic                commit_o,
    output logic                seq_exc_o,
    output logic                abort_o,
    output logic                abort_now_o,
    output logic [CODE_W-1:0]   abort_code_now_o,
    output logic                outer_begin_o
);

    localparam logic [DEPTH_W-1:0] MAX_D = DEPTH_W'(MAX_DEPTH);
    localparam logic [DEPTH_W-1:0] ONE_D = DEPTH_W'(1);

    logic [DEPTH_W-1:0] depth_q, depth_n;
    logic               con_q, con_n;
    logic               ccv_q, ccv_n;
    logic [1:0]         cc_q, cc_n;
    logic               commit_q, commit_n;
    logic               exc_q, exc_n;
    logic               abort_q, abort_n;
    logic [CODE_W-1:0]  code_n;
    logic               outer_n;

    // Next-state decision for depth, mode and strobes.
    always_comb begin
        depth_n = depth_q;
        con_n   = con_q;
        ccv_n   = 1'b0;
        cc_n    = CC_OK;
        commit_n = 1'b0;
        exc_n   = 1'b0;
        abort_n = 1'b0;
        code_n  = CODE_CONFLICT;
        outer_n = 1'b0;
        if (conflict_i && (depth_q != '0)) begin
            abort_n = 1'b1;
            code_n  = CODE_CONFLICT;
            cc_n    = CC_RETRY;
        end else if (op_valid_i) begin
            unique case (op_kind_i)
                TXOP_BEGIN: begin
                    if (con_q) begin
                        abort_n = 1'b1;
                        code_n  = CODE_CNEST;
                        cc_n    = CC_PERSIST;
                    end else if (depth_q == MAX_D) begin
                        abort_n = 1'b1;
                        code_n  = CODE_OVERFLOW;
                        cc_n    = CC_PERSIST;
                    end else begin
                        depth_n = depth_q + ONE_D;
                        ccv_n   = 1'b1;
                        outer_n = (depth_q == '0);
                    end
                end
                TXOP_CBEGIN: begin
                    if (depth_q != '0) begin
                        abort_n = 1'b1;
                        code_n  = CODE_CNEST;
                        cc_n    = CC_PERSIST;
                    end else begin
                        depth_n = ONE_D;
                        con_n   = 1'b1;
                        ccv_n   = 1'b1;
                        outer_n = 1'b1;
                    end
                end
                TXOP_END: begin
                    if (depth_q == '0) begin
                        exc_n = 1'b1;
                    end else if (depth_q == ONE_D) begin
                        commit_n = 1'b1;
                        depth_n  = '0;
                        con_n    = 1'b0;
                    end else begin
                        depth_n = depth_q - ONE_D;
                    end
                end
                TXOP_ABORT: begin
                    if (depth_q == '0) begin
                        exc_n = 1'b1;
                    end else begin
                        abort_n = 1'b1;
                        code_n  = op_code_i;
                        cc_n    = CC_RETRY;
                    end
                end
                default: ;
            endcase
        end
        if (abort_n) begin
            depth_n = '0;
            con_n   = 1'b0;
            ccv_n   = 1'b1;
        end
    end

    // State and strobe registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            depth_q  <= '0;
            con_q    <= 1'b0;
            ccv_q    <= 1'b0;
            cc_q     <= CC_OK;
            commit_q <= 1'b0;
            exc_q    <= 1'b0;
            abort_q  <= 1'b0;
        end else begin
            depth_q  <= depth_n;
            con_q    <= con_n;
            ccv_q    <= ccv_n;
            cc_q     <= cc_n;
            commit_q <= commit_n;
            exc_q    <= exc_n;
            abort_q  <= abort_n;
        end
    end

    assign depth_o          = depth_q;
    assign constrained_o    = con_q;
    assign cc_valid_o       = ccv_q;
    assign cc_o             = cc_q;
    assign commit_o         = commit_q;
    assign seq_exc_o        = exc_q;
    assign abort_o          = abort_q;
    assign abort_now_o      = abort_n;
    assign abort_code_now_o = code_n;
    assign outer_begin_o    = outer_n;

    a_r3_depth_bound: assert property (@(posedge clk) disable iff (!rst_n)
        depth_q <= MAX_D);

    a_r4_abort_unwinds: assert property (@(posedge clk) disable iff (!rst_n)
        abort_q |-> (depth_q == '0) && !con_q);

    a_r4_abort_cc_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        abort_q |-> ccv_q && (cc_q != CC_OK));

    a_r7_commit_from_one: assert property (@(posedge clk) disable iff (!rst_n)
        commit_q |-> ($past(depth_q) == ONE_D) && (depth_q == '0));

    a_r7_single_event: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({commit_q, abort_q, exc_q}));

    a_r2_depth_step: assert property (@(posedge clk) disable iff (!rst_n)
        !abort_q |-> (depth_q == $past(depth_q)) || (depth_q == $past(depth_q) + 1)
                     || (depth_q + 1 == $past(depth_q)));

endmodule

// File: rtl/tx_reg_snapshot.sv
`timescale 1ns/1ps
// Begin-time register snapshot.
// On an outermost begin it records the expanded restore mask, the
// resume address and the registers the mask selects. It presents them,
// masked, until the next outermost begin. Assumes the capture pulse
// is never raised in the same cycle as an abort.
module tx_reg_snapshot
    import tx_nest_pkg::*;
#(
    parameter int XLEN = 64,
    parameter int PC_W = 64
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      capture_i,
    input  logic [PAIR_CNT-1:0]       mask_i,
    input  logic [PC_W-1:0]           pc_i,
    input  logic [NUM_GPR*XLEN-1:0]   gpr_i,
    output logic [NUM_GPR-1:0]        mask_o,
    output logic [PC_W-1:0]           pc_o,
    output logic [NUM_GPR*XLEN-1:0]   data_o
);

    logic [NUM_GPR-1:0] mask_q;
    logic [PC_W-1:0]    pc_q;
    logic [NUM_GPR-1:0] mask_exp;

    assign mask_exp = pair_expand(mask_i);

    // Mask and resume address capture at the outermost begin.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
            pc_q   <= '0;
        end else if (capture_i) begin
            mask_q <= mask_exp;
            pc_q   <= pc_i;
        end
    end

    for (genvar g = 0; g < NUM_GPR; g++) begin : g_reg
        logic [XLEN-1:0] snap_q;

        // Capture one register when its pair is selected.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                snap_q <= '0;
            end else if (capture_i && mask_exp[g]) begin
                snap_q <= gpr_i[g*XLEN +: XLEN];
            end
        end

        assign data_o[g*XLEN +: XLEN] = mask_q[g] ? snap_q : '0;
    end

    assign mask_o = mask_q;
    assign pc_o   = pc_q;

    a_r9_mask_held: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(capture_i) |-> $stable(mask_q));

    a_r4_pc_held: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(capture_i) |-> $stable(pc_q));

endmodule

// File: rtl/tx_diag_writer.sv
`timescale 1ns/1ps
// Diagnostic record writer.
// On an abort it latches the code, depth, resume address and register
// file, then writes the 256-byte record one word per cycle from
// address 0. A further abort restarts the record. Assumes the register
// width and address width fit in one record word.
module tx_diag_writer
    import tx_nest_pkg::*;
#(
    parameter int XLEN    = 64,
    parameter int PC_W    = 64,
    parameter int DEPTH_W = 4,
    parameter int DIAG_W  = 64,
    parameter int ADDR_W  = 5
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start_i,
    input  logic [CODE_W-1:0]         code_i,
    input  logic [DEPTH_W-1:0]        depth_i,
    input  logic [PC_W-1:0]           pc_i,
    input  logic [NUM_GPR*XLEN-1:0]   gpr_i,
    output logic                      we_o,
    output logic [ADDR_W-1:0]         addr_o,
    output logic [DIAG_W-1:0]         data_o
);

    localparam int WORDS    = 2048 / DIAG_W;
    localparam int GPR_BASE = WORDS - NUM_GPR;
    localparam logic [ADDR_W-1:0] LAST_A = ADDR_W'(WORDS - 1);
    localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(GPR_BASE);

    logic               active_q;
    logic [ADDR_W-1:0]  idx_q;
    logic [CODE_W-1:0]  code_q;
    logic [DEPTH_W-1:0] depth_q;
    logic [PC_W-1:0]    pc_q;
    logic [XLEN-1:0]    regs_q [NUM_GPR];
    logic [3:0]         gsel;

    // Sequencer: start or restart on abort, step through the words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            idx_q    <= '0;
        end else if (start_i) begin
            active_q <= 1'b1;
            idx_q    <= '0;
        end else if (active_q) begin
            if (idx_q == LAST_A) begin
                active_q <= 1'b0;
            end else begin
                idx_q <= idx_q + 1'b1;
            end
        end
    end

    // Latch of the abort-time contents.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q  <= '0;
            depth_q <= '0;
            pc_q    <= '0;
            for (int i = 0; i < NUM_GPR; i++) regs_q[i] <= '0;
        end else if (start_i) begin
            code_q  <= code_i;
            depth_q <= depth_i;
            pc_q    <= pc_i;
            for (int i = 0; i < NUM_GPR; i++) regs_q[i] <= gpr_i[i*XLEN +: XLEN];
        end
    end

    // Word selection for the current record index.
    always_comb begin
        gsel = 4'(idx_q - BASE_A);
        if (idx_q == ADDR_W'(0)) begin
            data_o = DIAG_W'(code_q);
        end else if (idx_q == ADDR_W'(1)) begin
            data_o = DIAG_W'(depth_q);
        end else if (idx_q == ADDR_W'(2)) begin
            data_o = DIAG_W'(pc_q);
        end else if (idx_q >= BASE_A) begin
            data_o = DIAG_W'(regs_q[gsel]);
        end else begin
            data_o = '0;
        end
    end

    assign we_o   = active_q;
    assign addr_o = idx_q;

    a_r11_starts_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> we_o && (addr_o == '0));

    a_r11_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (we_o && (addr_o != '0)) |-> $past(we_o) && (addr_o == $past(addr_o) + 1));

endmodule

// File: rtl/tx_nest_ctrl.sv
`timescale 1ns/1ps
// Transaction nesting and abort controller, top level.
// Ties the depth and abort decision to the begin-time snapshot and the
// diagnostic writer. All results are registered and appear one cycle
// after the sampling edge. Assumes the core stalls its own operations
// while it applies a restore and redirect.
module tx_nest_ctrl
    import tx_nest_pkg::*;
#(
    parameter int MAX_DEPTH = 15,
    parameter int XLEN      = 64,
    parameter int PC_W      = 64,
    parameter int DIAG_W    = 64,
    localparam int DEPTH_W  = $clog2(MAX_DEPTH + 1),
    localparam int DIAG_AW  = $clog2(2048 / DIAG_W)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     op_valid_i,
    input  logic [2:0]               op_kind_i,
    input  logic [7:0]               op_mask_i,
    input  logic [7:0]               op_code_i,
    input  logic [PC_W-1:0]          op_pc_i,
    input  logic                     conflict_i,
    input  logic [16*XLEN-1:0]       gpr_i,
    output logic [DEPTH_W-1:0]       depth_o,
    output logic                     in_tx_o,
    output logic                     cc_valid_o,
    output logic [1:0]               cc_o,
    output logic                     commit_o,
    output logic                     discard_o,
    output logic                     seq_exc_o,
    output logic                     resume_valid_o,
    output logic [PC_W-1:0]          resume_pc_o,
    output logic                     restore_valid_o,
    output logic [15:0]              restore_mask_o,
    output logic [16*XLEN-1:0]       restore_data_o,
    output logic                     diag_we_o,
    output logic [DIAG_AW-1:0]       diag_addr_o,
    output logic [DIAG_W-1:0]        diag_data_o
);

    logic               abort_q;
    logic               abort_now;
    logic [CODE_W-1:0]  abort_code_now;
    logic               outer_begin;
    logic               constrained;
    logic [PC_W-1:0]    snap_pc;

    tx_depth_ctrl #(
        .MAX_DEPTH (MAX_DEPTH),
        .DEPTH_W   (DEPTH_W)
    ) u_depth (
        .clk              (clk),
        .rst_n            (rst_n),
        .op_valid_i       (op_valid_i),
        .op_kind_i        (txop_e'(op_kind_i)),
        .op_code_i        (op_code_i),
        .conflict_i       (conflict_i),
        .depth_o          (depth_o),
        .constrained_o    (constrained),
        .cc_valid_o       (cc_valid_o),
        .cc_o             (cc_o),
        .commit_o         (commit_o),
        .seq_exc_o        (seq_exc_o),
        .abort_o          (abort_q),
        .abort_now_o      (abort_now),
        .abort_code_now_o (abort_code_now),
        .outer_begin_o    (outer_begin)
    );

    tx_reg_snapshot #(
        .XLEN (XLEN),
        .PC_W (PC_W)
    ) u_snap (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture_i (outer_begin),
        .mask_i    (op_mask_i),
        .pc_i      (op_pc_i),
        .gpr_i     (gpr_i),
        .mask_o    (restore_mask_o),
        .pc_o      (snap_pc),
        .data_o    (restore_data_o)
    );

    tx_diag_writer #(
        .XLEN    (XLEN),
        .PC_W    (PC_W),
        .DEPTH_W (DEPTH_W),
        .DIAG_W  (DIAG_W),
        .ADDR_W  (DIAG_AW)
    ) u_diag (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (abort_now),
        .code_i  (abort_code_now),
        .depth_i (depth_o),
        .pc_i    (snap_pc),
        .gpr_i   (gpr_i),
        .we_o    (diag_we_o),
        .addr_o  (diag_addr_o),
        .data_o  (diag_data_o)
    );

    assign in_tx_o         = (depth_o != '0);
    assign discard_o       = abort_q;
    assign resume_valid_o  = abort_q;
    assign restore_valid_o = abort_q;
    assign resume_pc_o     = snap_pc;

    a_r10_constrained_depth: assert property (@(posedge clk) disable iff (!rst_n)
        constrained |-> (depth_o == DEPTH_W'(1)));

    a_r11_record_with_resume: assert property (@(posedge clk) disable iff (!rst_n)
        resume_valid_o |-> diag_we_o && (diag_addr_o == '0));

endmodule

// File: tb/tx_nest_ctrl_tb_top.sv
`timescale 1ns/1ps
// Self-checking bench: directed corners, then seeded random operations,
// compared against a bench-side model of the nesting state.
module tx_nest_ctrl_tb_top;

    localparam int MAXD = 15;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          op_valid = 1'b0;
    logic [2:0]    op_kind = '0;
    logic [7:0]    op_mask = '0;
    logic [7:0]    op_code = '0;
    logic [63:0]   op_pc = '0;
    logic          conflict = 1'b0;
    logic [1023:0] gpr = '0;

    logic [3:0]    depth_o;
    logic          in_tx_o, cc_valid_o, commit_o, discard_o, seq_exc_o;
    logic [1:0]    cc_o;
    logic          resume_valid_o, restore_valid_o, diag_we_o;
    logic [63:0]   resume_pc_o, diag_data_o;
    logic [15:0]   restore_mask_o;
    logic [1023:0] restore_data_o;
    logic [4:0]    diag_addr_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    int          m_depth = 0;
    bit          m_con = 1'b0;
    logic [63:0] m_pc = '0;
    logic [15:0] m_mask = '0;
    logic [63:0] m_snap [16];

    always #4 clk = ~clk;

    tx_nest_ctrl dut_i (
        .clk (clk), .rst_n (rst_n),
        .op_valid_i (op_valid), .op_kind_i (op_kind), .op_mask_i (op_mask),
        .op_code_i (op_code), .op_pc_i (op_pc), .conflict_i (conflict), .gpr_i (gpr),
        .depth_o (depth_o), .in_tx_o (in_tx_o), .cc_valid_o (cc_valid_o), .cc_o (cc_o),
        .commit_o (commit_o), .discard_o (discard_o), .seq_exc_o (seq_exc_o),
        .resume_valid_o (resume_valid_o), .resume_pc_o (resume_pc_o),
        .restore_valid_o (restore_valid_o), .restore_mask_o (restore_mask_o),
        .restore_data_o (restore_data_o), .diag_we_o (diag_we_o),
        .diag_addr_o (diag_addr_o), .diag_data_o (diag_data_o)
    );

    function automatic logic [15:0] expand(input logic [7:0] m);
        logic [15:0] r;
        for (int i = 0; i < 8; i++) begin
            r[2*i] = m[i];
            r[2*i+1] = m[i];
        end
        return r;
    endfunction

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // One operation: predict, drive on the falling edge, sample after the rising edge.
    task automatic step(input logic [2:0] kind, input logic [7:0] mask, input logic [7:0] code,
                        input logic [63:0] pc, input bit conf, input bit full_diag);
        bit ab = 0, ccv = 0, cm = 0, ex = 0, outer = 0;
        logic [1:0] ecc = 0;
        logic [7:0] ecode = 0;
        int nd = m_depth;
        string tag = "R2";
        string extag = "R7";
        logic [1023:0] g;
        logic [63:0] ew;
        for (int i = 0; i < 16; i++) g[i*64 +: 64] = {$urandom(), $urandom()};
        if (conf && m_depth != 0) begin
            ab = 1; ecode = 8'h02; ecc = 2; tag = "R5";
        end else begin
            case (kind)
                3'd1: if (m_con) begin ab = 1; ecode = 8'h04; ecc = 3; tag = "R10"; end
                      else if (m_depth == MAXD) begin ab = 1; ecode = 8'h03; ecc = 3; tag = "R3"; end
                      else begin ccv = 1; outer = (m_depth == 0); nd = m_depth + 1; end
                3'd2: if (m_depth != 0) begin ab = 1; ecode = 8'h04; ecc = 3; tag = "R10"; end
                      else begin ccv = 1; outer = 1; nd = 1; tag = "R10"; end
                3'd3: if (m_depth == 0) ex = 1;
                      else if (m_depth == 1) begin cm = 1; nd = 0; end
                      else nd = m_depth - 1;
                3'd4: if (m_depth == 0) begin ex = 1; extag = "R8"; end
                      else begin ab = 1; ecode = code; ecc = 2; tag = "R6"; end
                default: ;
            endcase
        end
        if (ab) begin ccv = 1; nd = 0; end
        @(negedge clk);
        op_valid = (kind != 3'd0); op_kind = kind; op_mask = mask; op_code = code;
        op_pc = pc; conflict = conf; gpr = g;
        @(posedge clk);
        #1;
        op_valid = 0; op_kind = 0; conflict = 0;
        chk(tag, "depth", 64'(depth_o), 64'(nd));
        chk("R1", "in_tx", 64'(in_tx_o), 64'(nd != 0));
        chk(tag, "cc_valid", 64'(cc_valid_o), 64'(ccv));
        if (ccv) chk(tag, "cc", 64'(cc_o), 64'(ecc));
        chk("R7", "commit", 64'(commit_o), 64'(cm));
        chk(extag, "seq_exc", 64'(seq_exc_o), 64'(ex));
        chk("R4", "discard", 64'(discard_o), 64'(ab));
        chk("R4", "resume_valid", 64'(resume_valid_o), 64'(ab));
        if (ab) begin
            chk("R4", "resume_pc", resume_pc_o, m_pc);
            chk("R9", "restore_valid", 64'(restore_valid_o), 64'd1);
            chk("R9", "restore_mask", 64'(restore_mask_o), 64'(m_mask));
            for (int i = 0; i < 16; i++)
                chk("R9", "restore_data", restore_data_o[i*64 +: 64], m_mask[i] ? m_snap[i] : 64'd0);
            chk("R11", "diag_we", 64'(diag_we_o), 64'd1);
            chk("R11", "diag_addr", 64'(diag_addr_o), 64'd0);
            chk(tag, "abort code word", diag_data_o, 64'(ecode));
            if (full_diag) begin
                for (int w = 1; w < 32; w++) begin
                    @(posedge clk);
                    #1;
                    if (w == 1) ew = 64'(m_depth);
                    else if (w == 2) ew = m_pc;
                    else if (w >= 16) ew = g[(w-16)*64 +: 64];
                    else ew = 64'd0;
                    chk("R11", "diag_we", 64'(diag_we_o), 64'd1);
                    chk("R11", "diag_addr", 64'(diag_addr_o), 64'(w));
                    chk("R11", "diag_word", diag_data_o, ew);
                end
            end
        end
        if (outer) begin
            m_pc = pc;
            m_mask = expand(mask);
            for (int i = 0; i < 16; i++) m_snap[i] = g[i*64 +: 64];
            if (kind == 3'd2) m_con = 1;
        end
        if (ab || cm) m_con = 0;
        m_depth = nd;
    endtask

    initial begin
        for (int i = 0; i < 16; i++) m_snap[i] = '0;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        chk("R1", "reset depth", 64'(depth_o), 64'd0);
        chk("R1", "reset in_tx", 64'(in_tx_o), 64'd0);
        chk("R1", "reset strobes", 64'({cc_valid_o, commit_o, discard_o, seq_exc_o, resume_valid_o, diag_we_o}), 64'd0);
        chk("R9", "reset restore_mask", 64'(restore_mask_o), 64'd0);

        // Outside a transaction: end, abort and conflict.
        step(3'd3, 8'h00, 8'h00, 64'h0, 0, 1);
        step(3'd4, 8'h00, 8'h11, 64'h0, 0, 1);
        step(3'd0, 8'h00, 8'h00, 64'h0, 1, 1);

        // Nested begins then two ends; inner mask and address ignored.
        step(3'd1, 8'h05, 8'h00, 64'h1000, 0, 1);
        step(3'd1, 8'hFF, 8'h00, 64'h2000, 0, 1);
        step(3'd3, 8'h00, 8'h00, 64'h0, 0, 1);
        step(3'd3, 8'h00, 8'h00, 64'h0, 0, 1);

        // Fill to the depth limit, then overflow.
        step(3'd1, 8'h81, 8'h00, 64'h3000, 0, 1);
        for (int i = 1; i < MAXD; i++) step(3'd1, 8'h3C, 8'h00, 64'h3100 + 64'(i), 0, 1);
        step(3'd1, 8'h00, 8'h00, 64'h3F00, 0, 1);

        // Constrained begin: commit, then nesting violations both ways.
        step(3'd2, 8'h0F, 8'h00, 64'h4000, 0, 1);
        step(3'd3, 8'h00, 8'h00, 64'h0, 0, 1);
        step(3'd2, 8'hF0, 8'h00, 64'h4100, 0, 1);
        step(3'd1, 8'h00, 8'h00, 64'h4200, 0, 1);
        step(3'd1, 8'h22, 8'h00, 64'h4300, 0, 1);
        step(3'd2, 8'h00, 8'h00, 64'h4400, 0, 1);

        // Conflict wins over an end at depth two.
        step(3'd1, 8'h44, 8'h00, 64'h5000, 0, 1);
        step(3'd1, 8'h00, 8'h00, 64'h5100, 0, 1);
        step(3'd3, 8'h00, 8'h00, 64'h0, 1, 1);

        // Explicit abort at depth three.
        step(3'd1, 8'hAA, 8'h00, 64'h6000, 0, 1);
        step(3'd1, 8'h00, 8'h00, 64'h6100, 0, 1);
        step(3'd1, 8'h00, 8'h00, 64'h6200, 0, 1);
        step(3'd4, 8'h00, 8'h5A, 64'h0, 0, 1);

        // Record restart: second abort while the first record is being written.
        step(3'd1, 8'h11, 8'h00, 64'h7000, 0, 1);
        step(3'd4, 8'h00, 8'h77, 64'h0, 0, 0);
        step(3'd1, 8'h99, 8'h00, 64'h7100, 0, 1);
        step(3'd0, 8'h00, 8'h00, 64'h0, 1, 1);

        // Seeded random operations.
        for (int n = 0; n < 400; n++) begin
            int r;
            logic [2:0] k;
            r = int'($urandom() % 100);
            if (r < 35) k = 3'd1;
            else if (r < 40) k = 3'd2;
            else if (r < 72) k = 3'd3;
            else if (r < 78) k = 3'd4;
            else k = 3'd0;
            step(k, 8'($urandom()), 8'($urandom()), {$urandom(), $urandom()},
                 ($urandom() % 100) < 6, 1);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule